// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Timing Engine

This block runs one programmed-I/O transfer on a parallel ATA bus at a time. A host hands it a register-select code, a direction, write data and a width flag (8-bit register access or 16-bit data access). The engine then walks the bus through address setup, strobe assertion and recovery, with every phase length taken from programmable clock counts. Register and data accesses each have their own active, recovery and total-cycle counts. The setup count is common to both.

The device may hold the strobe open by pulling IORDY low. The engine honours this only when told to, and it bounds the wait with a fixed cap that raises a timeout flag. Recovery is stretched so that the whole transfer meets the programmed cycle time. On writes, the data bus stays driven for a mode-dependent number of clocks after the write strobe rises. Read data is captured on the rising edge of the read strobe. Completion is reported by a one-clock done pulse.

Top module: `pio_cycle_engine`

## Requirements
- R1: Out of reset and whenever no transfer is in progress, both chip selects and both strobes are high, the data output enable is low, and `reqReady` is high.
- R2: From the cycle after acceptance until recovery ends, the bus shows the 5-bit select code as {busAddr[2:0], busCs1N, busCs0N} and holds it unchanged. Command-block registers use code (index<<2)|2. Alternate status and device control use 25.
- R3: The setup phase (selects driven, both strobes high) lasts max(tSetup,1) clocks.
- R4: In the active phase only the strobe for the direction is low: busDiorN for reads, busDiowN for writes. Without an IORDY hold, the active phase lasts max(A,1) clocks.
- R5: Register accesses take A, recovery and cycle counts from the 8-bit set. Data accesses take them from the 16-bit set. The timing inputs are sampled at acceptance.
- R6: When iordyEn is set, IORDY passes through a two-flop synchronizer. If IORDY is low at strobe start and rises during active clock j, the active phase lasts max(A, j+2) clocks.
- R7: IORDY waiting ends once the strobe has been low 51 clocks. A transfer ended this way sets `timeout`, which stays set until the next acceptance. With iordyEn clear, IORDY has no effect on the active length or on timeout.
- R8: Recovery, counted from strobe rise to the end of the transfer, lasts (C−L) clocks when that value exceeds the minimum recovery Rm. Otherwise it lasts Rm clocks, and never less than 1. L is the actual active length.
- R9: On reads, rdData takes the value of busDataIn present on the clock edge where busDiorN rises. It does not change at any other time.
- R10: On writes, busDataOe is high and busDataOut equals the request data for every clock that busDiowN is low.
- R11: After busDiowN rises, busDataOe stays high for W clocks: W=3 for pioMode 0, 2 for modes 1 and 2, and 1 otherwise. For writes, recovery is at least W clocks.
- R12: `reqReady` is high only when idle. A request is accepted on a clock edge with reqValid and reqReady both high. `done` is high for exactly one clock, the first idle clock after recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle, request can be taken |
| reqSel | input | 5 | {A2,A1,A0,CS1N,CS0N} select code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIsReg | input | 1 | 1 = 8-bit register timing, 0 = 16-bit data timing |
| reqWdata | input | DataW | Write data |
| pioMode | input | 3 | PIO mode, sets the post-write hold |
| iordyEn | input | 1 | Honour IORDY stretching |
| tSetup | input | CntW | Setup clocks (shared) |
| tAct8 | input | CntW | Register active clocks |
| tRec8 | input | CntW | Register minimum recovery |
| tCyc8 | input | CntW | Register cycle time |
| tAct16 | input | CntW | Data active clocks |
| tRec16 | input | CntW | Data minimum recovery |
| tCyc16 | input | CntW | Data cycle time |
| busCs0N | output | 1 | Chip select 0, active low |
| busCs1N | output | 1 | Chip select 1, active low |
| busAddr | output | 3 | Register address lines |
| busDiorN | output | 1 | Read strobe, active low |
| busDiowN | output | 1 | Write strobe, active low |
| busDataOut | output | DataW | Data to drive onto the bus |
| busDataOe | output | 1 | Bus output enable |
| busDataIn | input | DataW | Data from the bus |
| busIordy | input | 1 | Device ready, asynchronous |
| rdData | output | DataW | Captured read data |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | Last transfer hit the IORDY cap |

## Verification
The bound checker watches the invariants that hold on every clock. These are: the quiet idle bus, the two strobes never low together, the write enable covering every low write strobe, the steady select code during a transfer, read data moving only on a read-strobe rise, the single-clock done pulse, and a timeout rising only after exactly 51 strobe-low clocks. Phase lengths depend on the programmed counts, the selected timing set, the synchronizer delay and the recovery arithmetic, so only the bench scenarios can show them. The same holds for the captured read value and the write hold length. The bench measures these at the pins against a timing model written from the requirements.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } pioState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;      // request accepted this cycle
    logic selOn;     // drive chip selects and address
    logic strobeOn;  // active phase
    logic holdOn;    // post-write hold window
    logic capture;   // read strobe rises on this edge
  } pioCtl_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int CntW     = 8,
  parameter int IordyCap = 51
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [CntW-1:0] setupLen,
  input  logic [CntW-1:0] actMin,
  input  logic [CntW-1:0] recLen,
  input  logic [CntW-1:0] wstLen,
  input  logic            isWrite,
  input  logic            iordyUse,
  input  logic            iordySync,
  output pioCtl_t         ctl,
  output logic [CntW-1:0] actLen,
  output logic            reqReady,
  output logic            done,
  output logic            timeout
);

  localparam logic [CntW-1:0] CapCnt = CntW'(IordyCap);
  localparam logic [CntW-1:0] One    = CntW'(1);

  pioState_t       state;
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] recLenQ;
  logic            minMet;
  logic            iordyHold;
  logic            capHit;
  logic            exitAct;
  logic            exitTmo;
  logic            setupEnd;
  logic            recEnd;

  assign minMet    = cnt >= actMin;
  assign iordyHold = iordyUse && !iordySync;
  assign capHit    = cnt >= CapCnt;
  assign exitAct   = (state == ST_ACTIVE) && minMet && (!iordyHold || capHit);
  assign exitTmo   = exitAct && iordyHold;
  assign setupEnd  = (state == ST_SETUP) && (cnt >= setupLen);
  assign recEnd    = (state == ST_RECOVER) && (cnt >= recLenQ);
  assign actLen    = cnt;
  assign reqReady  = (state == ST_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && reqValid;
    ctl.selOn    = (state != ST_IDLE);
    ctl.strobeOn = (state == ST_ACTIVE);
    ctl.holdOn   = (state == ST_RECOVER) && isWrite && (cnt <= wstLen);
    ctl.capture  = exitAct && !isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      recLenQ <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= recEnd;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_SETUP;
            cnt     <= One;
            timeout <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (setupEnd) begin
            state <= ST_ACTIVE;
            cnt   <= One;
          end else begin
            cnt <= cnt + One;
          end
        end
        ST_ACTIVE: begin
          if (exitAct) begin
            state   <= ST_RECOVER;
            cnt     <= One;
            recLenQ <= recLen;
            timeout <= exitTmo;
          end else begin
            cnt <= cnt + One;
          end
        end
        ST_RECOVER: begin
          if (recEnd) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + One;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pio_dpath.sv
module pio_dpath
  import pio_pkg::*;
#(
  parameter int DataW      = 16,
  parameter int CntW       = 8,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pioCtl_t          ctl,
  input  logic [4:0]       reqSel,
  input  logic             reqWrite,
  input  logic             reqIsReg,
  input  logic [DataW-1:0] reqWdata,
  input  logic [2:0]       pioMode,
  input  logic             iordyEn,
  input  logic [CntW-1:0]  tSetup,
  input  logic [CntW-1:0]  tAct8,
  input  logic [CntW-1:0]  tRec8,
  input  logic [CntW-1:0]  tCyc8,
  input  logic [CntW-1:0]  tAct16,
  input  logic [CntW-1:0]  tRec16,
  input  logic [CntW-1:0]  tCyc16,
  input  logic [CntW-1:0]  actLen,
  input  logic             busIordy,
  input  logic [DataW-1:0] busDataIn,
  output logic [CntW-1:0]  setupLen,
  output logic [CntW-1:0]  actMin,
  output logic [CntW-1:0]  recLen,
  output logic [CntW-1:0]  wstLen,
  output logic             isWrite,
  output logic             iordyUse,
  output logic             iordySync,
  output logic             busCs0N,
  output logic             busCs1N,
  output logic [2:0]       busAddr,
  output logic             busDiorN,
  output logic             busDiowN,
  output logic [DataW-1:0] busDataOut,
  output logic             busDataOe,
  output logic [DataW-1:0] rdData
);

  localparam logic [CntW-1:0] One = CntW'(1);

  logic [4:0]       selQ;
  logic [DataW-1:0] wdQ;
  logic [CntW-1:0]  setupQ, actQ, recQ, cycQ;
  logic [CntW-1:0]  actPick, recPick, cycPick, wstPick;
  logic [CntW-1:0]  leftover, recBase, recFloor;
  logic [SyncStages-1:0] syncQ;

  // Timing set chosen by access width.
  always_comb begin
    if (reqIsReg) begin
      actPick = tAct8;
      recPick = tRec8;
      cycPick = tCyc8;
    end else begin
      actPick = tAct16;
      recPick = tRec16;
      cycPick = tCyc16;
    end
    unique case (pioMode)
      3'd0:       wstPick = CntW'(3);
      3'd1, 3'd2: wstPick = CntW'(2);
      default:    wstPick = CntW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ     <= 5'b00011;
      wdQ      <= '0;
      setupQ   <= One;
      actQ     <= One;
      recQ     <= One;
      cycQ     <= '0;
      wstLen   <= One;
      isWrite  <= 1'b0;
      iordyUse <= 1'b0;
    end else if (ctl.load) begin
      selQ     <= reqSel;
      wdQ      <= reqWdata;
      setupQ   <= (tSetup == '0) ? One : tSetup;
      actQ     <= (actPick == '0) ? One : actPick;
      recQ     <= recPick;
      cycQ     <= cycPick;
      wstLen   <= wstPick;
      isWrite  <= reqWrite;
      iordyUse <= iordyEn;
    end
  end

  // IORDY synchronizer chain.
  generate
    if (SyncStages == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= busIordy;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SyncStages-2:0], busIordy};
      end
    end
  endgenerate
  assign iordySync = syncQ[SyncStages-1];

  // Recovery length from the actual active length.
  always_comb begin
    leftover = (cycQ > actLen) ? (cycQ - actLen) : '0;
    recBase  = (leftover > recQ) ? leftover : recQ;
    recFloor = (recBase == '0) ? One : recBase;
    recLen   = (isWrite && (recFloor < wstLen)) ? wstLen : recFloor;
  end

  assign setupLen = setupQ;
  assign actMin   = actQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= busDataIn;
  end

  assign busCs0N    = ctl.selOn ? selQ[0] : 1'b1;
  assign busCs1N    = ctl.selOn ? selQ[1] : 1'b1;
  assign busAddr    = ctl.selOn ? selQ[4:2] : 3'b000;
  assign busDiorN   = !(ctl.strobeOn && !isWrite);
  assign busDiowN   = !(ctl.strobeOn && isWrite);
  assign busDataOut = wdQ;
  assign busDataOe  = (ctl.strobeOn && isWrite) || ctl.holdOn;

endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
  import pio_pkg::*;
#(
  parameter int DataW    = 16,
  parameter int CntW     = 8,
  parameter int IordyCap = 51
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [4:0]       reqSel,
  input  logic             reqWrite,
  input  logic             reqIsReg,
  input  logic [DataW-1:0] reqWdata,
  input  logic [2:0]       pioMode,
  input  logic             iordyEn,
  input  logic [CntW-1:0]  tSetup,
  input  logic [CntW-1:0]  tAct8,
  input  logic [CntW-1:0]  tRec8,
  input  logic [CntW-1:0]  tCyc8,
  input  logic [CntW-1:0]  tAct16,
  input  logic [CntW-1:0]  tRec16,
  input  logic [CntW-1:0]  tCyc16,
  output logic             busCs0N,
  output logic             busCs1N,
  output logic [2:0]       busAddr,
  output logic             busDiorN,
  output logic             busDiowN,
  output logic [DataW-1:0] busDataOut,
  output logic             busDataOe,
  input  logic [DataW-1:0] busDataIn,
  input  logic             busIordy,
  output logic [DataW-1:0] rdData,
  output logic             done,
  output logic             timeout
);

  pioCtl_t         ctl;
  logic [CntW-1:0] setupLen, actMin, recLen, wstLen, actLen;
  logic            isWrite, iordyUse, iordySync;

  pio_ctrl #(.CntW(CntW), .IordyCap(IordyCap)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .setupLen(setupLen), .actMin(actMin), .recLen(recLen), .wstLen(wstLen),
    .isWrite(isWrite), .iordyUse(iordyUse), .iordySync(iordySync),
    .ctl(ctl), .actLen(actLen), .reqReady(reqReady),
    .done(done), .timeout(timeout)
  );

  pio_dpath #(.DataW(DataW), .CntW(CntW), .SyncStages(2)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqSel(reqSel), .reqWrite(reqWrite), .reqIsReg(reqIsReg),
    .reqWdata(reqWdata), .pioMode(pioMode), .iordyEn(iordyEn),
    .tSetup(tSetup), .tAct8(tAct8), .tRec8(tRec8), .tCyc8(tCyc8),
    .tAct16(tAct16), .tRec16(tRec16), .tCyc16(tCyc16),
    .actLen(actLen), .busIordy(busIordy), .busDataIn(busDataIn),
    .setupLen(setupLen), .actMin(actMin), .recLen(recLen), .wstLen(wstLen),
    .isWrite(isWrite), .iordyUse(iordyUse), .iordySync(iordySync),
    .busCs0N(busCs0N), .busCs1N(busCs1N), .busAddr(busAddr),
    .busDiorN(busDiorN), .busDiowN(busDiowN),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .rdData(rdData)
  );

endmodule

// File: rtl/pio_cycle_checker.sv
module pio_cycle_checker #(
  parameter int DataW    = 16,
  parameter int IordyCap = 51
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             done,
  input logic             timeout,
  input logic             busCs0N,
  input logic             busCs1N,
  input logic [2:0]       busAddr,
  input logic             busDiorN,
  input logic             busDiowN,
  input logic             busDataOe,
  input logic [DataW-1:0] rdData
);

  logic [15:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     lowCnt <= '0;
    else if (!busDiorN || !busDiowN) lowCnt <= lowCnt + 16'd1;
    else                           lowCnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (busCs0N && busCs1N && busDiorN && busDiowN && !busDataOe));

  p_sel_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable({busAddr, busCs1N, busCs0N}));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!busDiorN && !busDiowN));

  p_cap_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> ($past(lowCnt) == 16'(IordyCap - 1)));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busDiorN && $past(busDiorN)) |-> $stable(rdData));

  p_wr_oe_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busDiowN |-> busDataOe);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind pio_cycle_engine pio_cycle_checker #(.DataW(DataW), .IordyCap(IordyCap)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .done(done), .timeout(timeout),
  .busCs0N(busCs0N), .busCs1N(busCs1N), .busAddr(busAddr),
  .busDiorN(busDiorN), .busDiowN(busDiowN), .busDataOe(busDataOe),
  .rdData(rdData)
);

// File: tb/sim_pio_cycle_engine.sv
`timescale 1ns/1ps
module sim_pio_cycle_engine;

  localparam int DataW = 16;
  localparam int CntW  = 8;
  localparam int Cap   = 51;

  logic clk = 0;
  logic rstN = 0;
  always #2 clk = ~clk;

  logic             reqValid = 0, reqReady, reqWrite = 0, reqIsReg = 0;
  logic [4:0]       reqSel = 0;
  logic [DataW-1:0] reqWdata = 0, busDataOut, busDataIn = 0, rdData;
  logic [2:0]       pioMode = 0;
  logic             iordyEn = 0, busIordy = 1;
  logic [CntW-1:0]  tSetup = 1, tAct8 = 1, tRec8 = 1, tCyc8 = 0;
  logic [CntW-1:0]  tAct16 = 1, tRec16 = 1, tCyc16 = 0;
  logic             busCs0N, busCs1N, busDiorN, busDiowN, busDataOe, done, timeout;
  logic [2:0]       busAddr;

  pio_cycle_engine #(.DataW(DataW), .CntW(CntW), .IordyCap(Cap)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSel(reqSel), .reqWrite(reqWrite), .reqIsReg(reqIsReg), .reqWdata(reqWdata),
    .pioMode(pioMode), .iordyEn(iordyEn), .tSetup(tSetup),
    .tAct8(tAct8), .tRec8(tRec8), .tCyc8(tCyc8),
    .tAct16(tAct16), .tRec16(tRec16), .tCyc16(tCyc16),
    .busCs0N(busCs0N), .busCs1N(busCs1N), .busAddr(busAddr),
    .busDiorN(busDiorN), .busDiowN(busDiowN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .busIordy(busIordy),
    .rdData(rdData), .done(done), .timeout(timeout)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0]       sel;
    logic             wr;
    int               setup, act, rec, hold;
    logic [DataW-1:0] data;
    logic             tmo;
    string            actTag;
  } exp_t;

  exp_t expQ[$];

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Driver: builds the expectation from the requirements, then runs the request.
  task automatic runTx(input logic [4:0] sel, input logic wr, input logic isReg,
                       input logic [DataW-1:0] val, input logic iordyLvl,
                       input int riseAt, input string actTag);
    exp_t e;
    int a, rm, c, w, diff, r, k;
    bit seenLow;
    a  = imax(isReg ? int'(tAct8) : int'(tAct16), 1);
    rm = isReg ? int'(tRec8) : int'(tRec16);
    c  = isReg ? int'(tCyc8) : int'(tCyc16);
    w  = (pioMode == 0) ? 3 : (pioMode <= 2) ? 2 : 1;
    e.tmo = 0;
    if (iordyEn && !iordyLvl && riseAt == 0) begin
      e.act = imax(a, Cap); e.tmo = 1;
    end else if (iordyEn && !iordyLvl) begin
      e.act = imax(a, riseAt + 2);
    end else begin
      e.act = a;
    end
    diff = (c > e.act) ? c - e.act : 0;
    r = (diff > rm) ? diff : rm;
    r = imax(r, 1);
    if (wr) r = imax(r, w);
    e.sel = sel; e.wr = wr; e.setup = imax(int'(tSetup), 1);
    e.rec = r; e.hold = wr ? w : 0; e.data = val; e.actTag = actTag;
    expQ.push_back(e);

    busIordy  = iordyLvl;
    busDataIn = wr ? 16'h0000 : val;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqSel = sel; reqWrite = wr; reqIsReg = isReg;
    reqWdata = wr ? val : 16'hFFFF;
    @(negedge clk);
    reqValid = 0;
    k = 0; seenLow = 0;
    while (!done) begin
      @(negedge clk);
      if (!(busDiorN && busDiowN)) begin
        seenLow = 1; k++;
        if (riseAt > 0 && k == riseAt) busIordy = 1;
      end else if (seenLow && !wr) begin
        busDataIn = ~val;   // R9: later bus values must not be captured
      end
    end
    @(negedge clk);
    chk("R12 done single clock", int'(done), 0);
    chk("R12 ready after done", int'(reqReady), 1);
  endtask

  // Monitor: measures each transfer at the pins and scores it.
  initial begin
    bit inTx = 0, readyBad = 0, oeBad = 0, dirBad = 0;
    int setupC = 0, actC = 0, recC = 0, holdC = 0;
    logic [4:0] seenSel = 0;
    logic [DataW-1:0] wdSeen = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!(busCs0N && busCs1N)) begin
          if (!inTx) begin
            inTx = 1; setupC = 0; actC = 0; recC = 0; holdC = 0;
            readyBad = 0; oeBad = 0; dirBad = 0;
            seenSel = {busAddr, busCs1N, busCs0N};
          end
          if (reqReady) readyBad = 1;
          if (!(busDiorN && busDiowN)) begin
            actC++;
            if (!busDiowN) begin
              wdSeen = busDataOut;
              if (!busDataOe) oeBad = 1;
            end
          end else if (actC == 0) begin
            setupC++;
          end else begin
            recC++;
            if (busDataOe) holdC++;
          end
          if (expQ.size() > 0) begin
            if (expQ[0].wr ? !busDiorN : !busDiowN) dirBad = 1;
          end
        end
        if (done) begin
          if (expQ.size() == 0) begin
            chk("R12 unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = expQ.pop_front();
            chk("R2 select code", int'(seenSel), int'(e.sel));
            chk("R3 setup clocks", setupC, e.setup);
            chk(e.actTag, actC, e.act);
            chk("R4 strobe direction", int'(dirBad), 0);
            chk("R8 recovery clocks", recC, e.rec);
            chk("R11 write hold clocks", holdC, e.hold);
            chk("R7 timeout flag", int'(timeout), int'(e.tmo));
            chk("R12 ready low while busy", int'(readyBad), 0);
            if (e.wr) begin
              chk("R10 write data", int'(wdSeen), int'(e.data));
              chk("R10 oe during write strobe", int'(oeBad), 0);
            end else begin
              chk("R9 read capture", int'(rdData), int'(e.data));
            end
          end
          inTx = 0;
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs0", int'(busCs0N), 1);
    chk("R1 reset cs1", int'(busCs1N), 1);
    chk("R1 reset strobes", int'({busDiorN, busDiowN}), 3);
    chk("R1 reset oe", int'(busDataOe), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle ready", int'(reqReady), 1);
    chk("R12 idle done", int'(done), 0);

    // R5 register set, mode 0 write: act 4, rec 12-4=8, hold 3
    pioMode = 0; tSetup = 2; tAct8 = 4; tRec8 = 2; tCyc8 = 12;
    tAct16 = 3; tRec16 = 5; tCyc16 = 6;
    runTx(5'd10, 1, 1, 16'h00A5, 1, 0, "R4 R5 reg active");
    // R5 data set read: act 3, rec max(3,5)=5
    runTx(5'd2, 0, 0, 16'h1234, 1, 0, "R4 R5 data active");
    // mode 4 data write: hold 1
    pioMode = 4;
    runTx(5'd2, 1, 0, 16'hBEEF, 1, 0, "R4 data write active");
    // R11 recovery raised to hold: rec 1 -> 3, alternate status code 25
    pioMode = 0; tAct8 = 2; tRec8 = 1; tCyc8 = 0;
    runTx(5'd25, 1, 1, 16'h005A, 1, 0, "R4 short reg write");
    // R3 zero setup becomes 1; read rec 1
    tSetup = 0;
    runTx(5'd25, 0, 1, 16'h00C3, 1, 0, "R4 alt read");
    // R6 iordy enabled but high: no stretch
    tSetup = 1; iordyEn = 1;
    runTx(5'd2, 0, 0, 16'h4321, 1, 0, "R6 iordy high active");
    // R6 stretch: rise in active clock 10 -> 12
    runTx(5'd2, 0, 0, 16'h8001, 0, 10, "R6 iordy stretch active");
    // R7 timeout at cap
    pioMode = 2;
    runTx(5'd2, 1, 0, 16'h7E7E, 0, 0, "R7 cap active");
    // R7 disabled iordy ignored, timeout cleared
    iordyEn = 0;
    runTx(5'd2, 0, 0, 16'h0F0F, 0, 0, "R7 iordy ignored active");
    // R8 long cycle: rec 20-3=17
    tCyc16 = 20;
    runTx(5'd6, 0, 0, 16'hA55A, 1, 0, "R8 long cycle active");

    repeat (3) @(negedge clk);
    chk("R1 idle cs after traffic", int'(busCs0N & busCs1N), 1);
    chk("R12 queue drained", expQ.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule